// File: doc/BRIEF.md
# Field-Triggered Memory Bus Sequencer

This block times the strobes around the external field memories of a video line-rate converter. One rising edge on the reference read-enable input marks the start of a field. From that edge every bus strobe and data-valid window is placed at its own cycle offset. Some buses add a programmable shift to that offset. Others add a delay of several whole input lines, because the processing pipeline holds three lines of data.

Each strobe or window is high for a set number of active pixel cycles, then low for the rest of the line. This pattern repeats once per line for a set number of lines, after which the output stays low until the next field. A shift value is read at the field edge only. A new rising edge restarts every bus in the same cycle, even in the middle of a field. The third-memory write bus is enabled by a memory-count input. The second output bus is enabled by a matrix-enable bit.

Top module: `field_bus_seq`

## Requirements
- R1: While reset is asserted, and after it until the first reference edge, every strobe and valid output is low.
- R2: The field edge is cycle 0. `c_rd_en` and `e_rd_en` go high in cycle 63 + `shift_ce`, and `ce_vld` goes high in cycle 63.
- R3: `a_rd_en` goes high in cycle 94 + `shift_a`, and `a_vld` goes high in cycle 94.
- R4: `f_vld` goes high in cycle 148 + 3·LINE_LEN, which falls while the fourth input line is being read.
- R5: `b_wr_en` goes high in cycle 160 + 4·LINE_LEN + `shift_bd`. `b_vld` goes high in cycle 160 + 4·LINE_LEN, which is one line after the output buses start.
- R6: Once started, every output is high for ACTIVE cycles in each LINE_LEN-cycle line, for FIELD_LINES lines, and then stays low.
- R7: `d_wr_en` and `d_vld` follow `b_wr_en` and `b_vld` only while `mem_count` equals 3 (binary 11). Otherwise they are low.
- R8: `g_vld` follows `f_vld` only while `matrix_en` is 1. Otherwise it is low.
- R9: The three 8-bit unsigned shift inputs are sampled at the field edge. Changing them later in the field does not move any strobe.
- R10: A rising edge on `ref_re` drives every output low in the cycle after the edge and restarts all timing from that edge. Holding `ref_re` high does not restart anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_re | input | 1 | Reference read enable; its rising edge starts a field |
| shift_a | input | 8 | Shift for the first memory read bus |
| shift_ce | input | 8 | Shift shared by the second and third memory read buses |
| shift_bd | input | 8 | Shift shared by the two memory write buses |
| mem_count | input | 2 | Number of field memories fitted |
| matrix_en | input | 1 | Enables the second output bus |
| a_rd_en | output | 1 | First memory read enable |
| a_vld | output | 1 | First memory read data valid window |
| c_rd_en | output | 1 | Second memory read enable |
| e_rd_en | output | 1 | Third memory read enable |
| ce_vld | output | 1 | Second/third memory read data valid window |
| f_vld | output | 1 | Main output bus data valid |
| g_vld | output | 1 | Second output bus data valid |
| b_wr_en | output | 1 | Second memory write enable |
| d_wr_en | output | 1 | Third memory write enable |
| b_vld | output | 1 | Second memory write data window |
| d_vld | output | 1 | Third memory write data window |

## Verification
The assertions check on every cycle that the gated D and G buses never run ahead of their enables or their partner buses. They also check that every output is low in the cycle after a field edge, and that each uninterrupted first-bus valid window lasts exactly the active pixel count.

The absolute start cycles can be shown only by the bench scenarios, which compare every output on every cycle against a cycle model. Those scenarios cover zero and maximum shifts, shift changes in the middle of a field, a held-high reference, and a retrigger in the middle of a field. The line repetition and the end of the field are checked the same way.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

   // channel indices of the window generators
   localparam int CH_A_RD   = 0;
   localparam int CH_A_VLD  = 1;
   localparam int CH_CE_RD  = 2;
   localparam int CH_CE_VLD = 3;
   localparam int CH_FG_VLD = 4;
   localparam int CH_BD_WR  = 5;
   localparam int CH_BD_VLD = 6;
   localparam int NUM_CH    = 7;

   // which programmable shift a channel adds
   localparam int SH_NONE = 0;
   localparam int SH_A    = 1;
   localparam int SH_CE   = 2;
   localparam int SH_BD   = 3;

   function automatic int width_of(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   function automatic int chan_lat(input int ch, input int a_lat, input int ce_lat,
                                   input int fg_lat, input int bd_lat);
      case (ch)
         CH_A_RD, CH_A_VLD:   return a_lat;
         CH_CE_RD, CH_CE_VLD: return ce_lat;
         CH_FG_VLD:           return fg_lat;
         default:             return bd_lat;
      endcase
   endfunction

   function automatic int chan_lines(input int ch, input int fg_lines, input int bd_lines);
      case (ch)
         CH_FG_VLD:           return fg_lines;
         CH_BD_WR, CH_BD_VLD: return bd_lines;
         default:             return 0;
      endcase
   endfunction

   function automatic int chan_shift(input int ch);
      case (ch)
         CH_A_RD:  return SH_A;
         CH_CE_RD: return SH_CE;
         CH_BD_WR: return SH_BD;
         default:  return SH_NONE;
      endcase
   endfunction

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/fbs_ref_edge.sv
module fbs_ref_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_re,
   output logic field_start
);
   logic ref_q;

   always_ff @(posedge clk) begin
      if (!rst_n) ref_q <= 1'b0;
      else        ref_q <= ref_re;
   end

   // only a low-to-high transition begins a field; a held level does not
   assign field_start = rst_n & ref_re & ~ref_q;
endmodule

// File: rtl/fbs_delay_timer.sv
module fbs_delay_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] load_val,
   output logic             go
);
   logic             busy;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= load_val;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   // fires on the edge that ends the countdown; the walker starts there
   assign go = busy & (cnt == '0) & ~start;
endmodule

// File: rtl/fbs_line_walker.sv
module fbs_line_walker #(
   parameter int LINE_LEN    = 200,
   parameter int ACTIVE      = 160,
   parameter int FIELD_LINES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic go,
   output logic win
);
   import fbs_pkg::*;

   localparam int PW = width_of(LINE_LEN);
   localparam int LW = width_of(FIELD_LINES);

   logic          running;
   logic [PW-1:0] pos;
   logic [LW-1:0] line;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         pos     <= '0;
         line    <= '0;
      end else if (start) begin
         running <= 1'b0;
         pos     <= '0;
         line    <= '0;
      end else if (go) begin
         running <= 1'b1;
         pos     <= '0;
         line    <= '0;
      end else if (running) begin
         if (pos == PW'(LINE_LEN - 1)) begin
            pos <= '0;
            if (line == LW'(FIELD_LINES - 1)) running <= 1'b0;
            else                             line    <= line + 1'b1;
         end else begin
            pos <= pos + 1'b1;
         end
      end
   end

   generate
      if (ACTIVE >= LINE_LEN) begin : g_full
         assign win = running;
      end else begin : g_part
         assign win = running & (pos < PW'(ACTIVE));
      end
   endgenerate
endmodule

// File: rtl/field_bus_seq.sv
module field_bus_seq
   import fbs_pkg::*;
#(
   parameter int LINE_LEN    = 200,
   parameter int ACTIVE      = 160,
   parameter int FIELD_LINES = 4,
   parameter int SHIFT_W     = 8,
   parameter int A_LAT       = 94,
   parameter int CE_LAT      = 63,
   parameter int FG_LAT      = 148,
   parameter int BD_LAT      = 160,
   parameter int FG_LINES    = 3,
   parameter int BD_LINES    = 4,
   parameter int MEM_W       = 2,
   parameter int THIRD_MEM   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ref_re,
   input  logic [SHIFT_W-1:0] shift_a,
   input  logic [SHIFT_W-1:0] shift_ce,
   input  logic [SHIFT_W-1:0] shift_bd,
   input  logic [MEM_W-1:0]   mem_count,
   input  logic               matrix_en,
   output logic               a_rd_en,
   output logic               a_vld,
   output logic               c_rd_en,
   output logic               e_rd_en,
   output logic               ce_vld,
   output logic               f_vld,
   output logic               g_vld,
   output logic               b_wr_en,
   output logic               d_wr_en,
   output logic               b_vld,
   output logic               d_vld
);

   localparam int MAX_BASE  = max4(A_LAT, CE_LAT, FG_LAT + FG_LINES * LINE_LEN,
                                   BD_LAT + BD_LINES * LINE_LEN);
   localparam int MAX_DELAY = MAX_BASE + (1 << SHIFT_W) - 1;
   localparam int CNT_W     = width_of(MAX_DELAY + 1);

   // elaboration-time parameter checks
   if (ACTIVE < 1 || ACTIVE > LINE_LEN) begin : g_bad_active
      $error("ACTIVE must lie in 1..LINE_LEN");
   end
   if (FIELD_LINES < 1) begin : g_bad_lines
      $error("FIELD_LINES must be at least 1");
   end
   if (A_LAT < 1 || CE_LAT < 1 || FG_LAT < 1 || BD_LAT < 1) begin : g_bad_lat
      $error("every bus latency must be at least one cycle");
   end
   if (THIRD_MEM >= (1 << MEM_W)) begin : g_bad_mem
      $error("THIRD_MEM does not fit in MEM_W bits");
   end

   logic              field_start;
   logic [NUM_CH-1:0] win;
   logic              third_fitted;

   fbs_ref_edge u_edge (
      .clk         (clk),
      .rst_n       (rst_n),
      .ref_re      (ref_re),
      .field_start (field_start)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam int BASE = chan_lat(ch, A_LAT, CE_LAT, FG_LAT, BD_LAT)
                          + chan_lines(ch, FG_LINES, BD_LINES) * LINE_LEN;
      localparam int SEL  = chan_shift(ch);

      logic [SHIFT_W-1:0] sh;
      logic [CNT_W-1:0]   load_val;
      logic               go;

      if (SEL == SH_A) begin : g_sa
         assign sh = shift_a;
      end else if (SEL == SH_CE) begin : g_sce
         assign sh = shift_ce;
      end else if (SEL == SH_BD) begin : g_sbd
         assign sh = shift_bd;
      end else begin : g_s0
         assign sh = '0;
      end

      // the shift is taken only when the timer loads at the field edge
      assign load_val = CNT_W'(BASE - 1) + CNT_W'(sh);

      fbs_delay_timer #(.CNT_W(CNT_W)) u_timer (
         .clk      (clk),
         .rst_n    (rst_n),
         .start    (field_start),
         .load_val (load_val),
         .go       (go)
      );

      fbs_line_walker #(
         .LINE_LEN    (LINE_LEN),
         .ACTIVE      (ACTIVE),
         .FIELD_LINES (FIELD_LINES)
      ) u_walk (
         .clk   (clk),
         .rst_n (rst_n),
         .start (field_start),
         .go    (go),
         .win   (win[ch])
      );
   end

   assign third_fitted = (mem_count == MEM_W'(THIRD_MEM));

   assign a_rd_en = win[CH_A_RD];
   assign a_vld   = win[CH_A_VLD];
   assign c_rd_en = win[CH_CE_RD];
   assign e_rd_en = win[CH_CE_RD];
   assign ce_vld  = win[CH_CE_VLD];
   assign f_vld   = win[CH_FG_VLD];
   assign g_vld   = win[CH_FG_VLD] & matrix_en;
   assign b_wr_en = win[CH_BD_WR];
   assign d_wr_en = win[CH_BD_WR] & third_fitted;
   assign b_vld   = win[CH_BD_VLD];
   assign d_vld   = win[CH_BD_VLD] & third_fitted;

endmodule

// File: rtl/field_bus_seq_chk.sv
module field_bus_seq_chk #(
   parameter int ACTIVE    = 160,
   parameter int MEM_W     = 2,
   parameter int THIRD_MEM = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ref_re,
   input logic [MEM_W-1:0] mem_count,
   input logic             matrix_en,
   input logic             a_rd_en,
   input logic             a_vld,
   input logic             c_rd_en,
   input logic             e_rd_en,
   input logic             ce_vld,
   input logic             f_vld,
   input logic             g_vld,
   input logic             b_wr_en,
   input logic             d_wr_en,
   input logic             b_vld,
   input logic             d_vld
);
   logic ref_prev;
   logic start_seen;
   int   run_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_prev   <= 1'b0;
         start_seen <= 1'b0;
         run_len    <= 0;
      end else begin
         ref_prev   <= ref_re;
         start_seen <= ref_re & ~ref_prev;
         run_len    <= a_vld ? run_len + 1 : 0;
      end
   end

   // R7
   d_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_wr_en | d_vld) |-> (mem_count == MEM_W'(THIRD_MEM)) && (d_wr_en ? b_wr_en : b_vld));

   // R8
   g_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      g_vld |-> (matrix_en && f_vld));

   // R10
   restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_seen |-> !(a_rd_en | a_vld | c_rd_en | e_rd_en | ce_vld | f_vld
                       | g_vld | b_wr_en | d_wr_en | b_vld | d_vld));

   // R6
   run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(a_vld) && !start_seen) |-> (run_len == ACTIVE));

   // R2
   ce_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_rd_en == e_rd_en);

endmodule

bind field_bus_seq field_bus_seq_chk #(
   .ACTIVE    (ACTIVE),
   .MEM_W     (MEM_W),
   .THIRD_MEM (THIRD_MEM)
) u_chk (.*);

// File: tb/field_bus_seq_tb.sv
module field_bus_seq_tb;
   localparam int LINE_LEN    = 200;
   localparam int ACTIVE      = 160;
   localparam int FIELD_LINES = 4;
   localparam int FIELD_CYC   = 2300;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_re = 1'b0;
   logic [7:0] shift_a = '0, shift_ce = '0, shift_bd = '0;
   logic [1:0] mem_count = 2'd3;
   logic       matrix_en = 1'b1;
   logic a_rd_en, a_vld, c_rd_en, e_rd_en, ce_vld, f_vld, g_vld;
   logic b_wr_en, d_wr_en, b_vld, d_vld;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model state
   bit ref_prev = 1'b0;
   bit run = 1'b0;
   int t = 0;
   int ca = 0, cce = 0, cbd = 0;

   always #2 clk = ~clk;

   field_bus_seq #(
      .LINE_LEN(LINE_LEN), .ACTIVE(ACTIVE), .FIELD_LINES(FIELD_LINES)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .ref_re(ref_re),
      .shift_a(shift_a), .shift_ce(shift_ce), .shift_bd(shift_bd),
      .mem_count(mem_count), .matrix_en(matrix_en),
      .a_rd_en(a_rd_en), .a_vld(a_vld), .c_rd_en(c_rd_en), .e_rd_en(e_rd_en),
      .ce_vld(ce_vld), .f_vld(f_vld), .g_vld(g_vld),
      .b_wr_en(b_wr_en), .d_wr_en(d_wr_en), .b_vld(b_vld), .d_vld(d_vld)
   );

   function automatic bit win(input int d);
      if (!run || t < d) return 1'b0;
      if ((t - d) >= FIELD_LINES * LINE_LEN) return 1'b0;
      return ((t - d) % LINE_LEN) < ACTIVE;
   endfunction

   task automatic chk(input string req, input string name, input bit act, input bit exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s at t=%0d: actual %0b expected %0b", req, name, t, act, exp);
      end
   endtask

   task automatic compare();
      bit third;
      third = (mem_count == 2'd3);
      chk("R3 R9 R10", "a_rd_en", a_rd_en, win(94 + ca));
      chk("R3 R10",    "a_vld",   a_vld,   win(94));
      chk("R2 R9 R10", "c_rd_en", c_rd_en, win(63 + cce));
      chk("R2 R9 R10", "e_rd_en", e_rd_en, win(63 + cce));
      chk("R2 R6",     "ce_vld",  ce_vld,  win(63));
      chk("R4 R6",     "f_vld",   f_vld,   win(148 + 3 * LINE_LEN));
      chk("R8",        "g_vld",   g_vld,   win(148 + 3 * LINE_LEN) & matrix_en);
      chk("R5 R9",     "b_wr_en", b_wr_en, win(160 + 4 * LINE_LEN + cbd));
      chk("R7",        "d_wr_en", d_wr_en, win(160 + 4 * LINE_LEN + cbd) & third);
      chk("R5 R6",     "b_vld",   b_vld,   win(160 + 4 * LINE_LEN));
      chk("R7",        "d_vld",   d_vld,   win(160 + 4 * LINE_LEN) & third);
   endtask

   // one clock: update model at the edge, compare at the falling edge
   task automatic tick();
      @(posedge clk);
      if (!rst_n) begin
         ref_prev = 1'b0;
         run = 1'b0;
      end else begin
         if (ref_re && !ref_prev) begin
            t = 0;
            run = 1'b1;
            ca = shift_a; cce = shift_ce; cbd = shift_bd;
         end else if (run) begin
            t++;
         end
         ref_prev = ref_re;
      end
      @(negedge clk);
      compare();
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic fire();
      ref_re = 1'b0;
      tick();
      ref_re = 1'b1;
      tick();
      tick();
      ref_re = 1'b0;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0F1D));
      // R1: outputs low in and after reset
      ticks(5);
      @(negedge clk);
      rst_n = 1'b1;
      ticks(20);

      // zero shifts, all buses enabled
      shift_a = 8'd0; shift_ce = 8'd0; shift_bd = 8'd0;
      mem_count = 2'd3; matrix_en = 1'b1;
      fire();
      ticks(FIELD_CYC);

      // maximum shifts, D and G disabled, reference held high (R10 level)
      shift_a = 8'd255; shift_ce = 8'd255; shift_bd = 8'd255;
      mem_count = 2'd2; matrix_en = 1'b0;
      ref_re = 1'b0;
      tick();
      ref_re = 1'b1;
      ticks(FIELD_CYC);
      ref_re = 1'b0;
      ticks(5);

      // R9: shifts change in mid-field
      shift_a = 8'($urandom); shift_ce = 8'($urandom); shift_bd = 8'($urandom);
      mem_count = 2'd3; matrix_en = 1'b1;
      fire();
      ticks(40);
      shift_a = 8'($urandom); shift_ce = 8'($urandom); shift_bd = 8'($urandom);
      ticks(FIELD_CYC);

      // R10: retrigger inside the active region of every bus
      fire();
      ticks(1000);
      shift_a = 8'd17; shift_ce = 8'd3; shift_bd = 8'd200;
      fire();
      ticks(FIELD_CYC);

      // random fields with configuration toggling
      for (int f = 0; f < 4; f++) begin
         shift_a = 8'($urandom); shift_ce = 8'($urandom); shift_bd = 8'($urandom);
         fire();
         for (int c = 0; c < FIELD_CYC; c++) begin
            if (($urandom % 300) == 0) mem_count = 2'($urandom);
            if (($urandom % 300) == 0) matrix_en = ~matrix_en;
            tick();
         end
      end

      // R1: a reset in mid-field clears everything
      fire();
      ticks(1100);
      rst_n = 1'b0;
      ticks(3);
      rst_n = 1'b1;
      ticks(2500);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule